// File: doc/BRIEF.md
# Buffered Serial Flash Page-Program Engine

This block writes data to a serial NOR flash over a single-lane SPI link (mode 0). It has two modes. In buffered mode, the host first streams a 128-byte page into an internal buffer through a 32-bit word port. In unbuffered mode, no page is loaded. A pulse on the start input then opens one chip-select window. In that window the block sends:

1. the opcode,
2. a 3- or 4-byte address, most significant byte first,
3. either the whole page (buffered mode) or one byte taken from a byte input (unbuffered mode).

Every field is sent on one lane.

The host selects buffered mode through a request/acknowledge pair. It drives the request level and waits until the acknowledge reads back the same value before it loads words or starts a transfer. The acknowledge follows the request only while the engine is idle. As a result, the mode cannot change inside a chip-select window.

The word port is a valid/ready stream. A word is taken on every rising clock edge at which `word_valid_i` and `word_ready_o` are both high. Ready is held low in three cases: buffered mode is not acknowledged, a transfer is in progress, or 32 words are already stored. The host may hold valid high with stable data until ready rises. Words offered while ready is low are not stored.

Top module: `snor_pgm_engine`

## Requirements
- R1: After reset, `cs_n_o` is 1, and `sck_o`, `busy_o`, `buf_en_ack_o` and `word_ready_o` are 0.
- R2: While `busy_o` is 0, `buf_en_ack_o` takes the value of `buf_en_req_i` one clock later. While `busy_o` is 1, `buf_en_ack_o` holds its value.
- R3: `word_ready_o` is 1 only when `buf_en_ack_o` is 1, `busy_o` is 0 and fewer than 32 words are stored. Each accepted word adds four page bytes in this order: bits [7:0], [15:8], [23:16], [31:24]. A word offered while ready is 0 is dropped.
- R4: A `go_i` pulse while idle makes `busy_o` 1 and `cs_n_o` 0 one clock later. A `go_i` pulse while busy has no effect.
- R5: Each frame starts with the opcode byte, followed by the address most significant byte first. When `addr4_i` is 0 the address is `addr_i[23:16]`, `[15:8]`, `[7:0]`. When `addr4_i` is 1 the address is four bytes, starting with `addr_i[31:24]`.
- R6: If `buf_en_ack_o` is 1 at start, exactly 128 data bytes follow the address. Page byte i comes from stored word i/4, bits [8*(i%4)+7 : 8*(i%4)].
- R7: If `buf_en_ack_o` is 0 at start, exactly one data byte (`single_byte_i`) follows the address.
- R8: Serial timing:
  - Every byte is sent most significant bit first.
  - Each bit spends one clock with `sck_o` low, then one clock with `sck_o` high.
  - `mosi_o` is stable while `sck_o` is high.
  - `sck_o` is 0 whenever `cs_n_o` is 1.
  - After the last bit, `cs_n_o` returns to 1 and `busy_o` to 0.
- R9: The word write position returns to 0 in two cases: a buffered frame completes, or `buf_en_ack_o` falls. If a buffered frame starts after only k words were loaded, it sends those k words followed by the older buffer contents from word k onward.
- R10: Opcode, address, address length and single byte are captured at start. Changing those inputs during a frame does not alter the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| buf_en_req_i | input | 1 | Requested buffered mode |
| buf_en_ack_o | output | 1 | Buffered mode in effect (read back) |
| word_valid_i | input | 1 | Page word offered |
| word_ready_o | output | 1 | Page word can be accepted |
| word_data_i | input | 32 | Page word, least significant byte is sent first |
| opcode_i | input | 8 | Program opcode |
| addr_i | input | 32 | Flash byte address |
| addr4_i | input | 1 | 1 selects 4-byte address, 0 selects 3-byte |
| single_byte_i | input | 8 | Data byte for unbuffered program |
| go_i | input | 1 | Start pulse |
| busy_o | output | 1 | Frame in progress; clears itself when done |
| cs_n_o | output | 1 | Flash chip select, active low |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to flash |

## Verification
The bound checker checks the following on every cycle:
- the serial clock stays low outside the chip-select window;
- the clock toggles on every cycle inside the window;
- a start while idle opens the window on the next clock;
- the mode acknowledge follows the request while idle and holds while busy.

Only the bench's scenarios can show what the frames carry. A scoreboard compares every serial byte against the expected frame. Those scenarios cover:
- the full and the partial (stale-content) page;
- 3- and 4-byte addressing;
- the single-byte path;
- pointer reset on disable;
- dropped words when the buffer is full;
- input changes and repeated starts during a frame.

// File: rtl/snor_pgm_pkg.sv
package snor_pgm_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    SEG_OPCODE,
    SEG_ADDR,
    SEG_DATA
  } seg_e;
endpackage

// File: rtl/snor_pgm_pagebuf.sv
module snor_pgm_pagebuf #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned BIDX_W = 7,
  parameter int unsigned PTR_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              clr_i,
  output logic              full_o,
  input  logic [BIDX_W-1:0] rd_idx_i,
  output logic [7:0]        rd_byte_o
);
  localparam int unsigned LANES  = WORD_W / 8;
  localparam int unsigned LANE_W = $clog2(LANES);
  localparam int unsigned WIDX_W = BIDX_W - LANE_W;

  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  ptr_q;
  logic [WORD_W-1:0] rd_word;

  assign full_o = (ptr_q == PTR_W'(DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (clr_i) begin
      ptr_q <= '0;
    end else if (push_i && !full_o) begin
      ptr_q <= ptr_q + PTR_W'(1);
    end
  end

  // storage has no reset: stale contents are part of the contract
  always_ff @(posedge clk) begin
    if (push_i && !full_o && !clr_i) begin
      mem_q[ptr_q[WIDX_W-1:0]] <= word_i;
    end
  end

  assign rd_word   = mem_q[rd_idx_i[BIDX_W-1:LANE_W]];
  assign rd_byte_o = 8'(rd_word >> {rd_idx_i[LANE_W-1:0], 3'b000});
endmodule

// File: rtl/snor_pgm_framer.sv
module snor_pgm_framer
  import snor_pgm_pkg::*;
#(
  parameter int unsigned PAGE_BYTES     = 128,
  parameter int unsigned ADDR_MAX_BYTES = 4,
  parameter int unsigned CNT_W          = 8,
  parameter int unsigned BIDX_W         = 7
) (
  input  logic [CNT_W-1:0]            idx_i,
  input  logic [7:0]                  opcode_i,
  input  logic [8*ADDR_MAX_BYTES-1:0] addr_i,
  input  logic                        addr4_i,
  input  logic                        buffered_i,
  input  logic [7:0]                  single_i,
  input  logic [7:0]                  buf_byte_i,
  output logic [BIDX_W-1:0]           rd_idx_o,
  output logic [7:0]                  byte_o,
  output logic [CNT_W-1:0]            total_o
);
  logic [CNT_W-1:0] alen;
  logic [CNT_W-1:0] data_base;
  logic [CNT_W-1:0] shift_b;
  seg_e             seg;

  assign alen      = addr4_i ? CNT_W'(ADDR_MAX_BYTES) : CNT_W'(ADDR_MAX_BYTES - 1);
  assign data_base = alen + CNT_W'(1);
  assign total_o   = data_base + (buffered_i ? CNT_W'(PAGE_BYTES) : CNT_W'(1));
  assign shift_b   = alen - idx_i;

  always_comb begin
    if (idx_i == '0)          seg = SEG_OPCODE;
    else if (idx_i <= alen)   seg = SEG_ADDR;
    else                      seg = SEG_DATA;
  end

  always_comb begin
    rd_idx_o = '0;
    unique case (seg)
      SEG_OPCODE: byte_o = opcode_i;
      SEG_ADDR:   byte_o = 8'(addr_i >> {shift_b, 3'b000});
      default: begin
        rd_idx_o = BIDX_W'(idx_i - data_base);
        byte_o   = buffered_i ? buf_byte_i : single_i;
      end
    endcase
  end
endmodule

// File: rtl/snor_pgm_serializer.sv
module snor_pgm_serializer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] total_i,
  input  logic [7:0]       byte_i,
  output logic [CNT_W-1:0] idx_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             sck_o,
  output logic             mosi_o
);
  logic             busy_q;
  logic             phase_q;
  logic [2:0]       bit_q;
  logic [CNT_W-1:0] idx_q;
  logic             last_byte;

  assign last_byte = (idx_q == total_i - CNT_W'(1));
  assign done_o    = busy_q && phase_q && (bit_q == 3'd0) && last_byte;
  assign idx_o     = idx_q;
  assign busy_o    = busy_q;
  assign sck_o     = busy_q && phase_q;
  assign mosi_o    = busy_q && byte_i[bit_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      phase_q <= 1'b0;
      bit_q   <= 3'd7;
      idx_q   <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q  <= 1'b1;
        phase_q <= 1'b0;
        bit_q   <= 3'd7;
        idx_q   <= '0;
      end
    end else begin
      phase_q <= ~phase_q;
      if (phase_q) begin
        if (bit_q != 3'd0) begin
          bit_q <= bit_q - 3'd1;
        end else if (last_byte) begin
          busy_q <= 1'b0;
        end else begin
          bit_q <= 3'd7;
          idx_q <= idx_q + CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/snor_pgm_engine.sv
module snor_pgm_engine #(
  parameter int unsigned PAGE_BYTES     = 128,
  parameter int unsigned WORD_W         = 32,
  parameter int unsigned ADDR_MAX_BYTES = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        buf_en_req_i,
  output logic                        buf_en_ack_o,
  input  logic                        word_valid_i,
  output logic                        word_ready_o,
  input  logic [WORD_W-1:0]           word_data_i,
  input  logic [7:0]                  opcode_i,
  input  logic [8*ADDR_MAX_BYTES-1:0] addr_i,
  input  logic                        addr4_i,
  input  logic [7:0]                  single_byte_i,
  input  logic                        go_i,
  output logic                        busy_o,
  output logic                        cs_n_o,
  output logic                        sck_o,
  output logic                        mosi_o
);
  localparam int unsigned LANES  = WORD_W / 8;
  localparam int unsigned DEPTH  = PAGE_BYTES / LANES;
  localparam int unsigned PTR_W  = $clog2(DEPTH + 1);
  localparam int unsigned BIDX_W = $clog2(PAGE_BYTES);
  localparam int unsigned CNT_W  = $clog2(1 + ADDR_MAX_BYTES + PAGE_BYTES + 1);

  logic                        ack_q;
  logic [7:0]                  op_q;
  logic [8*ADDR_MAX_BYTES-1:0] addr_q;
  logic                        a4_q;
  logic [7:0]                  one_q;
  logic                        buf_q;

  logic                        busy;
  logic                        done;
  logic                        start;
  logic                        full;
  logic                        push;
  logic                        clr;
  logic [CNT_W-1:0]            idx;
  logic [CNT_W-1:0]            total;
  logic [BIDX_W-1:0]           rd_idx;
  logic [7:0]                  buf_byte;
  logic [7:0]                  cur_byte;

  assign start        = go_i && !busy;
  assign word_ready_o = ack_q && !busy && !full;
  assign push         = word_valid_i && word_ready_o;
  assign clr          = (!busy && ack_q && !buf_en_req_i) || (done && buf_q);
  assign buf_en_ack_o = ack_q;
  assign busy_o       = busy;
  assign cs_n_o       = !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q  <= 1'b0;
      op_q   <= '0;
      addr_q <= '0;
      a4_q   <= 1'b0;
      one_q  <= '0;
      buf_q  <= 1'b0;
    end else if (!busy) begin
      ack_q <= buf_en_req_i;
      if (start) begin
        op_q   <= opcode_i;
        addr_q <= addr_i;
        a4_q   <= addr4_i;
        one_q  <= single_byte_i;
        buf_q  <= ack_q;
      end
    end
  end

  snor_pgm_pagebuf #(
    .WORD_W(WORD_W), .DEPTH(DEPTH), .BIDX_W(BIDX_W), .PTR_W(PTR_W)
  ) u_buf (
    .clk(clk), .rst_n(rst_n), .push_i(push), .word_i(word_data_i),
    .clr_i(clr), .full_o(full), .rd_idx_i(rd_idx), .rd_byte_o(buf_byte)
  );

  snor_pgm_framer #(
    .PAGE_BYTES(PAGE_BYTES), .ADDR_MAX_BYTES(ADDR_MAX_BYTES),
    .CNT_W(CNT_W), .BIDX_W(BIDX_W)
  ) u_frm (
    .idx_i(idx), .opcode_i(op_q), .addr_i(addr_q), .addr4_i(a4_q),
    .buffered_i(buf_q), .single_i(one_q), .buf_byte_i(buf_byte),
    .rd_idx_o(rd_idx), .byte_o(cur_byte), .total_o(total)
  );

  snor_pgm_serializer #(
    .CNT_W(CNT_W)
  ) u_ser (
    .clk(clk), .rst_n(rst_n), .start_i(start), .total_i(total),
    .byte_i(cur_byte), .idx_o(idx), .busy_o(busy), .done_o(done),
    .sck_o(sck_o), .mosi_o(mosi_o)
  );
endmodule

// File: rtl/snor_pgm_engine_chk.sv
module snor_pgm_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic buf_en_req_i,
  input logic buf_en_ack_o,
  input logic go_i,
  input logic busy_o,
  input logic cs_n_o,
  input logic sck_o
);
  assert_sck_idle_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> !sck_o);

  assert_sck_toggles_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> (sck_o != $past(sck_o)));

  assert_start_opens_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (go_i && !busy_o) |=> (busy_o && !cs_n_o));

  assert_ack_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |=> (buf_en_ack_o == $past(buf_en_req_i)));

  assert_ack_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(buf_en_ack_o));
endmodule

bind snor_pgm_engine snor_pgm_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .buf_en_req_i(buf_en_req_i),
  .buf_en_ack_o(buf_en_ack_o), .go_i(go_i), .busy_o(busy_o),
  .cs_n_o(cs_n_o), .sck_o(sck_o)
);

// File: tb/snor_pgm_engine_tb.sv
`timescale 1ns/1ps
module snor_pgm_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        buf_en_req_i = 1'b0;
  logic        buf_en_ack_o;
  logic        word_valid_i = 1'b0;
  logic        word_ready_o;
  logic [31:0] word_data_i = '0;
  logic [7:0]  opcode_i = '0;
  logic [31:0] addr_i = '0;
  logic        addr4_i = 1'b0;
  logic [7:0]  single_byte_i = '0;
  logic        go_i = 1'b0;
  logic        busy_o, cs_n_o, sck_o, mosi_o;

  int checks = 0;
  int errors = 0;
  logic [7:0]  exp_q [$];
  string       tag_q [$];
  logic [31:0] model [32];
  int          bptr = 0;

  always #4 clk = ~clk;

  snor_pgm_engine u_dut (
    .clk(clk), .rst_n(rst_n), .buf_en_req_i(buf_en_req_i),
    .buf_en_ack_o(buf_en_ack_o), .word_valid_i(word_valid_i),
    .word_ready_o(word_ready_o), .word_data_i(word_data_i),
    .opcode_i(opcode_i), .addr_i(addr_i), .addr4_i(addr4_i),
    .single_byte_i(single_byte_i), .go_i(go_i), .busy_o(busy_o),
    .cs_n_o(cs_n_o), .sck_o(sck_o), .mosi_o(mosi_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // monitor: collect bits on sck rise, compare bytes against the scoreboard
  initial begin
    logic [7:0] sh = '0;
    int nbits = 0;
    forever begin
      @(posedge sck_o or posedge cs_n_o);
      #2;
      if (cs_n_o) begin
        chk(nbits == 0 && exp_q.size() == 0, "R8 frame length", nbits, exp_q.size());
        nbits = 0;
      end else begin
        logic b1;
        b1 = mosi_o;
        #4;
        if (mosi_o !== b1) chk(1'b0, "R8 mosi stable while sck high", mosi_o, b1);
        sh = {sh[6:0], b1};
        nbits++;
        if (nbits == 8) begin
          nbits = 0;
          if (exp_q.size() == 0) begin
            chk(1'b0, "R8 extra byte in frame", sh, 0);
          end else begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(sh == e, t, sh, e);
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R8 actual=timeout expected=completion");
    summary();
    $finish;
  end

  task automatic push_exp(input logic [7:0] b, input string t);
    exp_q.push_back(b);
    tag_q.push_back(t);
  endtask

  task automatic exp_frame(input logic [7:0] op, input logic [31:0] a, input bit a4,
                           input bit buffered, input logic [7:0] one, input int nfresh);
    int n;
    push_exp(op, "R5 opcode");
    n = a4 ? 4 : 3;
    for (int k = n - 1; k >= 0; k--) push_exp(8'(a >> (8 * k)), "R5 address byte");
    if (buffered) begin
      for (int i = 0; i < 128; i++)
        push_exp(8'(model[i / 4] >> (8 * (i % 4))),
                 (i / 4 < nfresh) ? "R6 page byte" : "R9 stale byte");
    end else begin
      push_exp(one, "R7 single byte");
    end
  endtask

  task automatic push_word(input logic [31:0] w);
    @(negedge clk);
    chk(word_ready_o == 1'b1, "R3 ready while loading", word_ready_o, 1);
    word_valid_i = 1'b1;
    word_data_i  = w;
    @(negedge clk);
    word_valid_i = 1'b0;
    model[bptr] = w;
    bptr++;
  endtask

  task automatic set_req(input bit v);
    @(negedge clk);
    buf_en_req_i = v;
    @(negedge clk);
    chk(buf_en_ack_o == v, "R2 ack follows request", buf_en_ack_o, v);
    if (!v) bptr = 0;
  endtask

  task automatic fire(input logic [7:0] op, input logic [31:0] a, input bit a4, input logic [7:0] one);
    @(negedge clk);
    opcode_i = op; addr_i = a; addr4_i = a4; single_byte_i = one;
    go_i = 1'b1;
    @(negedge clk);
    go_i = 1'b0;
    chk(busy_o && !cs_n_o, "R4 start opens window", {busy_o, cs_n_o}, 2'b10);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy_o) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R8 all expected bytes sent", exp_q.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n_o == 1 && sck_o == 0 && busy_o == 0 && buf_en_ack_o == 0 && word_ready_o == 0,
        "R1 reset state", {cs_n_o, sck_o, busy_o, buf_en_ack_o, word_ready_o}, 5'b10000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(word_ready_o == 0, "R3 no ready while buffer mode off", word_ready_o, 0);

    // full page, 3-byte address
    set_req(1'b1);
    for (int i = 0; i < 32; i++) push_word(32'hA000_0000 | (i * 32'h0001_0203) ^ 32'h0F1E_2D3C);
    @(negedge clk);
    chk(word_ready_o == 0, "R3 ready low when 32 words stored", word_ready_o, 0);
    word_valid_i = 1'b1; word_data_i = 32'hDEAD_BEEF;  // must be dropped
    repeat (2) @(negedge clk);
    word_valid_i = 1'b0;
    exp_frame(8'h02, 32'h0012_3456, 1'b0, 1'b1, 8'h00, 32);
    fire(8'h02, 32'h0012_3456, 1'b0, 8'h00);
    // R10: change inputs mid-frame, R4: repeated start ignored, R2: ack held
    opcode_i = 8'hFF; addr_i = 32'hFFFF_FFFF; addr4_i = 1'b1; single_byte_i = 8'hEE;
    buf_en_req_i = 1'b0;
    go_i = 1'b1;
    @(negedge clk);
    go_i = 1'b0;
    @(negedge clk);
    chk(buf_en_ack_o == 1, "R2 ack held while busy", buf_en_ack_o, 1);
    buf_en_req_i = 1'b1;
    wait_idle();
    bptr = 0;  // R9 completion resets pointer

    // partial page, 4-byte address: stale tail
    for (int i = 0; i < 5; i++) push_word(32'h5500_0000 + i * 32'h0101_0101);
    @(negedge clk);
    chk(word_ready_o == 1, "R3 ready with partial buffer", word_ready_o, 1);
    exp_frame(8'h12, 32'h89AB_CDEF, 1'b1, 1'b1, 8'h00, 5);
    fire(8'h12, 32'h89AB_CDEF, 1'b1, 8'h00);
    wait_idle();
    bptr = 0;

    // unbuffered single byte
    set_req(1'b0);
    chk(word_ready_o == 0, "R3 ready low when unbuffered", word_ready_o, 0);
    exp_frame(8'h02, 32'h00AB_CDEF, 1'b0, 1'b0, 8'h5A, 0);
    fire(8'h02, 32'h00AB_CDEF, 1'b0, 8'h5A);
    wait_idle();

    // pointer reset by disabling buffered mode
    set_req(1'b1);
    for (int i = 0; i < 3; i++) push_word(32'hD0D0_0000 + i);
    set_req(1'b0);
    set_req(1'b1);
    for (int i = 0; i < 2; i++) push_word(32'hE1E2_E300 + i);
    exp_frame(8'h32, 32'h0000_0100, 1'b0, 1'b1, 8'h00, 2);
    fire(8'h32, 32'h0000_0100, 1'b0, 8'h00);
    wait_idle();

    summary();
    $finish;
  end
endmodule